// File: doc/BRIEF.md
# Interrupt-Acknowledge Bus Cycle Generator

This block runs the master side of one interrupt-acknowledge read on a 32-bit external bus. A request carries the 3-bit interrupt level being serviced. Once accepted, the block drives a fixed address pattern and the control fields that mark the access as an interrupt acknowledge. It raises the transfer-start strobe for one clock and then waits for the slave to answer with a transfer acknowledge. On that acknowledge it takes the vector byte from the top byte lane of the data bus.

The result is an 8-bit vector and a one-clock completion pulse. An optional timeout is set by a limit input. If the slave does not answer within that many waiting clocks, the cycle is dropped and a one-clock error pulse is raised instead. Between cycles every bus output falls back to zero, so an external multiplexer or tri-state stage can use the bus-enable output directly.

Top module: `iack_cycle_gen`

## Requirements
- R1: After reset, bus_drive, bus_start, busy, done and err are 0, and bus_addr, bus_rd, bus_size, bus_ttype, bus_tmod and vec_out are all zero.
- R2: While bus_drive is 1, bus_addr equals 0xFFFFFFE0 plus four times the accepted level: bits 31:5 are all ones, bits 4:2 hold the level and bits 1:0 are zero.
- R3: While bus_drive is 1, bus_rd is 1 (read), bus_size is 2'b01 (byte), bus_ttype is 2'b11 (interrupt acknowledge), and bus_tmod holds the accepted level, unchanged for the whole cycle.
- R4: bus_start is 1 for exactly one clock: the first clock after the accepting edge, with bus_drive also 1. It is 0 in every later clock of the cycle.
- R5: At the first rising edge in the waiting phase where bus_ack is 1, vec_out is loaded from bus_data[31:24]. done is 1 for exactly the next clock, and bus_data[23:0] has no effect on vec_out.
- R6: bus_ack during the clock in which bus_start is 1 is ignored. The cycle enters the waiting phase and neither done nor err follows.
- R7: A request is accepted only when busy is 0. A request seen while busy is 1, including the done or err clock, is ignored, and bus_tmod keeps the level of the running cycle.
- R8: With tmo_limit = L > 0, a cycle that sees no bus_ack in its first L waiting clocks ends with err high for one clock, no done, and vec_out unchanged. An acknowledge in the L-th waiting clock still completes normally.
- R9: With tmo_limit = 0 there is no timeout: the cycle waits for bus_ack without limit.
- R10: In every clock outside the address and waiting phases, including the done and err clocks, bus_drive and bus_start are 0, and bus_addr, bus_rd, bus_size, bus_ttype and bus_tmod are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request to acknowledge an interrupt |
| req_level | input | 3 | Interrupt level carried by the request |
| tmo_limit | input | TMO_W | Waiting clocks allowed before abort; 0 disables |
| bus_ack | input | 1 | Transfer acknowledge from the slave |
| bus_data | input | DATA_W | External data bus |
| bus_drive | output | 1 | Bus enable: the block owns address and control |
| bus_start | output | 1 | Transfer-start strobe |
| bus_addr | output | 32 | Address bus |
| bus_rd | output | 1 | Read/write, 1 = read |
| bus_size | output | 2 | Transfer size |
| bus_ttype | output | 2 | Transfer type |
| bus_tmod | output | 3 | Transfer modifier |
| busy | output | 1 | A cycle is in progress (includes the done/err clock) |
| vec_out | output | VEC_W | Last captured vector |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | One-clock timeout pulse |

## Verification
Each fault in the controller's state shows up at the ports within one or two clocks. A state stuck in the address phase shows as a second start strobe. A state that leaves the waiting phase too early shows as done or err without an acknowledge, or as bus_drive falling while the slave is still expected to answer. A level register loaded again mid-cycle shows at once on bus_tmod and bus_addr. An off-by-one in the timeout counter moves the err pulse by exactly one clock, or makes a boundary acknowledge fail. For these reasons the timeout limits and the waiting lengths are swept together around the boundary.

// File: rtl/iack_pkg.sv
package iack_pkg;

  localparam int IACK_ADDR_W = 32;
  localparam int IACK_LVL_W  = 3;

  localparam logic [1:0] SIZE_BYTE = 2'b01;
  localparam logic [1:0] TT_IACK   = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_DONE,
    ST_ERR
  } iack_state_t;

  // Upper field all ones, level in the middle, low two bits zero.
  function automatic logic [IACK_ADDR_W-1:0] iack_addr(input logic [IACK_LVL_W-1:0] lvl);
    return {{(IACK_ADDR_W-IACK_LVL_W-2){1'b1}}, lvl, 2'b00};
  endfunction

endpackage

// File: rtl/iack_tmo.sv
module iack_tmo #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);

  logic [TMO_W-1:0] cnt_q;

  // Expire on the limit-th waiting clock; a zero limit never expires.
  assign expire = run && (limit != '0) && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (!expire) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/iack_ctrl.sv
module iack_ctrl
  import iack_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [IACK_LVL_W-1:0] req_level,
  input  logic                  ack,
  input  logic                  expire,
  output iack_state_t           state,
  output logic [IACK_LVL_W-1:0] level,
  output logic                  accept_evt,
  output logic                  capture_evt,
  output logic                  abort_evt
);

  iack_state_t state_q, state_d;
  logic [IACK_LVL_W-1:0] level_q;

  assign accept_evt  = (state_q == ST_IDLE) && req_valid;
  assign capture_evt = (state_q == ST_WAIT) && ack;
  assign abort_evt   = (state_q == ST_WAIT) && !ack && expire;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_evt) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_WAIT;
      ST_WAIT: begin
        if (capture_evt)    state_d = ST_DONE;
        else if (abort_evt) state_d = ST_ERR;
      end
      ST_DONE: state_d = ST_IDLE;
      ST_ERR:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      level_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept_evt) level_q <= req_level;
    end
  end

  assign state = state_q;
  assign level = level_q;

endmodule

// File: rtl/iack_capture.sv
module iack_capture #(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  output logic [VEC_W-1:0]  vec
);

  localparam int LO_W = DATA_W - VEC_W;

  logic [VEC_W-1:0] vec_q;
  logic             unused_low;

  assign unused_low = ^data[LO_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    vec_q <= '0;
    else if (load) vec_q <= data[DATA_W-1 -: VEC_W];
  end

  assign vec = vec_q;

endmodule

// File: rtl/iack_cycle_gen.sv
module iack_cycle_gen
  import iack_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8,
  parameter int TMO_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [IACK_LVL_W-1:0]  req_level,
  input  logic [TMO_W-1:0]       tmo_limit,
  input  logic                   bus_ack,
  input  logic [DATA_W-1:0]      bus_data,
  output logic                   bus_drive,
  output logic                   bus_start,
  output logic [IACK_ADDR_W-1:0] bus_addr,
  output logic                   bus_rd,
  output logic [1:0]             bus_size,
  output logic [1:0]             bus_ttype,
  output logic [IACK_LVL_W-1:0]  bus_tmod,
  output logic                   busy,
  output logic [VEC_W-1:0]       vec_out,
  output logic                   done,
  output logic                   err
);

  iack_state_t           state;
  logic [IACK_LVL_W-1:0] level;
  logic                  accept_evt, capture_evt, abort_evt, expire;
  logic                  in_wait;

  assign in_wait = (state == ST_WAIT);

  iack_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_level   (req_level),
    .ack         (bus_ack),
    .expire      (expire),
    .state       (state),
    .level       (level),
    .accept_evt  (accept_evt),
    .capture_evt (capture_evt),
    .abort_evt   (abort_evt)
  );

  iack_tmo #(.TMO_W(TMO_W)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (in_wait),
    .limit  (tmo_limit),
    .expire (expire)
  );

  iack_capture #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (capture_evt),
    .data  (bus_data),
    .vec   (vec_out)
  );

  always_comb begin
    bus_drive = (state == ST_ADDR) || in_wait;
    bus_start = (state == ST_ADDR);
    bus_addr  = '0;
    bus_rd    = 1'b0;
    bus_size  = '0;
    bus_ttype = '0;
    bus_tmod  = '0;
    if (bus_drive) begin
      bus_addr  = iack_addr(level);
      bus_rd    = 1'b1;
      bus_size  = SIZE_BYTE;
      bus_ttype = TT_IACK;
      bus_tmod  = level;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
  assign err  = (state == ST_ERR);

endmodule

// File: rtl/iack_cycle_gen_chk.sv
module iack_cycle_gen_chk #(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_ack,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_drive,
  input logic              bus_start,
  input logic [31:0]       bus_addr,
  input logic              bus_rd,
  input logic [1:0]        bus_size,
  input logic [1:0]        bus_ttype,
  input logic [2:0]        bus_tmod,
  input logic              busy,
  input logic [VEC_W-1:0]  vec_out,
  input logic              done,
  input logic              err,
  input logic              accept_evt,
  input logic              capture_evt,
  input logic              abort_evt
);

  assert_addr_fmt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> bus_addr == {27'h7FFFFFF, bus_tmod, 2'b00});

  assert_ctrl_codes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (bus_rd && bus_size == 2'b01 && bus_ttype == 2'b11));

  assert_tmod_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive && $past(bus_drive)) |-> $stable(bus_tmod));

  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !bus_start);

  assert_start_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |-> bus_drive);

  assert_capture_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> (done && vec_out == $past(bus_data[DATA_W-1 -: VEC_W])));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ack_in_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (bus_drive && !done && !err));

  assert_accept_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept_evt);

  assert_accept_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> bus_start);

  assert_abort_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (err && !done && $stable(vec_out)));

  assert_done_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive |-> (!bus_start && bus_addr == '0 && !bus_rd &&
                    bus_size == '0 && bus_ttype == '0 && bus_tmod == '0));

  assert_end_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !bus_drive);

endmodule

bind iack_cycle_gen iack_cycle_gen_chk #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_ack     (bus_ack),
  .bus_data    (bus_data),
  .bus_drive   (bus_drive),
  .bus_start   (bus_start),
  .bus_addr    (bus_addr),
  .bus_rd      (bus_rd),
  .bus_size    (bus_size),
  .bus_ttype   (bus_ttype),
  .bus_tmod    (bus_tmod),
  .busy        (busy),
  .vec_out     (vec_out),
  .done        (done),
  .err         (err),
  .accept_evt  (accept_evt),
  .capture_evt (capture_evt),
  .abort_evt   (abort_evt)
);

// File: tb/iack_cycle_gen_bench.sv
module iack_cycle_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_level = '0;
  logic [7:0]  tmo_limit = '0;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_data = '0;
  logic        bus_drive, bus_start, bus_rd, busy, done, err;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size, bus_ttype;
  logic [2:0]  bus_tmod;
  logic [7:0]  vec_out;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] last_vec = '0;

  always #4 clk = ~clk;

  iack_cycle_gen u_iack_cycle_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .tmo_limit(tmo_limit), .bus_ack(bus_ack), .bus_data(bus_data),
    .bus_drive(bus_drive), .bus_start(bus_start), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_size(bus_size), .bus_ttype(bus_ttype),
    .bus_tmod(bus_tmod), .busy(busy), .vec_out(vec_out), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input int lvl);
    return 32'hFFFF_FFFF - 31 + lvl * 4;
  endfunction

  // Control fields packed as {rd, size, ttype, tmod}
  function automatic logic [7:0] exp_ctrl(input int lvl);
    return 8'h80 + 8'h08 + 8'h30 + lvl[7:0];
  endfunction

  task automatic check_quiet(input string tag);
    chk(!bus_drive && !bus_start, {tag, " drive/start low"}, {bus_drive, bus_start}, 0);
    chk(bus_addr == 0, {tag, " addr zero"}, bus_addr, 0);
    chk({bus_rd, bus_size, bus_ttype, bus_tmod} == 0, {tag, " ctrl zero"},
        {bus_rd, bus_size, bus_ttype, bus_tmod}, 0);
  endtask

  // Full cycle: nwait waiting clocks without ack, then ack with data d
  task automatic run_cycle(input int lvl, input int nwait, input int limit, input logic [31:0] d);
    tmo_limit = limit[7:0];
    req_valid = 1'b1; req_level = lvl[2:0]; bus_ack = 1'b0;
    @(negedge clk);
    req_level = ~lvl[2:0];
    chk(bus_start && bus_drive, "R4 start in first clock", {bus_start, bus_drive}, 3);
    chk(bus_addr == exp_addr(lvl), "R2 address", bus_addr, exp_addr(lvl));
    chk({bus_rd, bus_size, bus_ttype, bus_tmod} == exp_ctrl(lvl), "R3 control",
        {bus_rd, bus_size, bus_ttype, bus_tmod}, exp_ctrl(lvl));
    bus_ack = 1'b1; bus_data = ~d;
    for (int i = 0; i <= nwait; i++) begin
      @(negedge clk);
      chk(!bus_start, "R4 start negated", bus_start, 0);
      chk(bus_drive && bus_tmod == lvl[2:0], "R3/R7 tmod held", bus_tmod, lvl);
      chk(bus_addr == exp_addr(lvl), "R7 address held", bus_addr, exp_addr(lvl));
      chk(!done && !err, "R6/R9 no early end", {done, err}, 0);
      bus_ack = (i == nwait);
      bus_data = (i == nwait) ? d : ~d;
    end
    @(negedge clk);
    last_vec = d[31:24];
    chk(done && !err, "R5/R8 done", {done, err}, 2);
    chk(vec_out == last_vec, "R5 vector", vec_out, last_vec);
    check_quiet("R10 done clock");
    bus_ack = 1'b0; bus_data = 32'h0;
    req_valid = 1'b1; req_level = lvl[2:0] ^ 3'd1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!done, "R5 done one clock", done, 0);
    chk(!busy && !bus_start, "R7 request in done clock ignored", {busy, bus_start}, 0);
  endtask

  task automatic run_timeout(input int lvl, input int lim);
    tmo_limit = lim[7:0];
    req_valid = 1'b1; req_level = lvl[2:0]; bus_ack = 1'b0;
    bus_data = 32'hA5A5_A5A5;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      chk(!err && bus_drive, "R8 waiting before limit", {err, bus_drive}, 1);
    end
    @(negedge clk);
    chk(err && !done, "R8 err pulse", {err, done}, 2);
    chk(vec_out == last_vec, "R8 vector unchanged", vec_out, last_vec);
    check_quiet("R10 err clock");
    @(negedge clk);
    chk(!err && !busy, "R8 err one clock", {err, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_drive && !busy && !done && !err, "R1 reset flags",
        {bus_drive, busy, done, err}, 0);
    chk(vec_out == 0, "R1 reset vector", vec_out, 0);
    check_quiet("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_start, "R1 idle after reset", {busy, bus_start}, 0);

    for (int lvl = 0; lvl < 8; lvl++)
      for (int w = 0; w < 4; w++)
        for (int m = 0; m < 2; m++) begin
          logic [7:0] v = 8'(lvl * 37 + w * 11 + m * 90 + 5);
          run_cycle(lvl, w, (m == 1) ? w + 1 : 0, {v, ~v, v ^ 8'h5A, 8'hC3});
        end

    for (int lvl = 0; lvl < 8; lvl++)
      for (int lim = 1; lim <= 4; lim++)
        run_timeout(lvl, lim);

    run_cycle(5, 30, 0, 32'h3C00_FFFF);  // R9 long wait, no timeout
    run_cycle(2, 6, 7, 32'hE7FF_0000);   // R8 ack on last allowed clock

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule